// File: doc/BRIEF.md
# Event Counter Sampling Window Buffer

This block turns seven single-cycle event strobes from a memory hierarchy into a time series of per-event counts for a downstream attack classifier. Each event has its own saturating counter. A time base fires once every `SAMPLE_CYC` enabled clock cycles. When it fires, all seven counters are captured as one sample and restarted in the same cycle. Each sample is pushed into a shift buffer that holds the newest `WIN_LEN` samples.

When the shift buffer completes a window, the whole window is copied into a separate window store. At that point `win_valid` rises and the classifier reads the window one sample at a time through an index port, oldest sample first. The newest half of every window is reused as the older half of the next one. The first window therefore appears after `WIN_LEN` samples, and each later window appears after `WIN_LEN/2` fresh samples. With the default parameters (100-cycle sample interval, 100-sample window, 1 GHz clock) this gives 100 ns samples and 10 µs windows, with a new window every 5 µs.

The consumer holds off window replacement only by acknowledging in time. A window that completes while the previous one is still unacknowledged overwrites it and raises a sticky overrun flag.

Top module: `evwin_top`

## Requirements
- R1: Each sample records, per event, the number of enabled cycles in which that event's strobe was high since the previous sample. Strobe bit order is: bit 0 L1 data miss, bit 1 L1 data hit, bit 2 L1 instruction miss, bit 3 L1 instruction hit, bit 4 last-level cache hit, bit 5 DRAM row miss, bit 6 DRAM row hit.
- R2: A count stops at 2^CNT_W-1 and does not wrap.
- R3: The time base counts enabled cycles from reset. A sample is taken on enabled cycle number SAMPLE_CYC-1, 2·SAMPLE_CYC-1, and so on. A strobe in a sampling cycle counts toward the next sample, not the one being taken.
- R4: The first window after reset becomes valid on the clock edge of the WIN_LEN-th sample. `win_valid` is high from the following cycle.
- R5: Every later window completes after WIN_LEN/2 further samples. Its first WIN_LEN/2 samples are the last WIN_LEN/2 samples of the previous window.
- R6: `win_valid` stays high until a cycle with `win_ack` high, and is low in the cycle after that ack unless a new window completes on the same edge.
- R7: If a window completes while `win_valid` is high and `win_ack` is low, `overrun` goes high and stays high until reset. The window store then holds the newer window.
- R8: While `en` is low, strobes are not counted and the time base does not advance.
- R9: Synchronous reset clears the counters, the time base, the buffer fill level, `win_valid` and `overrun`.
- R10: `rd_data` shows window sample `rd_idx` combinationally, with index 0 the oldest. Event e is in bits [e·CNT_W +: CNT_W]. An index at or beyond WIN_LEN reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counting and time base enable |
| ev_strobe | input | 7 | One strobe per event, order as in R1 |
| win_ack | input | 1 | Consumer acknowledge of the current window |
| rd_idx | input | clog2(WIN_LEN) | Sample index within the window store |
| win_valid | output | 1 | A window is waiting for the consumer |
| overrun | output | 1 | Sticky flag: an unacknowledged window was replaced |
| rd_data | output | 7·CNT_W | Seven counts of the addressed sample |

## Verification
A fault in the counters or the time base shows as a wrong count in the next window read out. With the small bench configuration that readout comes within a few dozen cycles. A slip of the fill level or of the half-window reuse shifts the `win_valid` rise by whole sample intervals. It also misaligns every sample index of the following window. Errors in the valid and overrun state show in the very cycle after the edge that should have changed them, because the bench compares both flags every cycle.

// File: rtl/evwin_pkg.sv
package evwin_pkg;

    localparam int NUM_EV = 7;

    typedef enum logic [2:0] {
        EV_L1D_MISS = 3'd0,
        EV_L1D_HIT  = 3'd1,
        EV_L1I_MISS = 3'd2,
        EV_L1I_HIT  = 3'd3,
        EV_LLC_HIT  = 3'd4,
        EV_ROW_MISS = 3'd5,
        EV_ROW_HIT  = 3'd6
    } ev_id_e;

    function automatic int win_half(input int len);
        return len / 2;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/evwin_tick.sv
module evwin_tick #(
    parameter int SAMPLE_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    import evwin_pkg::*;

    localparam int TB_W = idx_width(SAMPLE_CYC);
    localparam logic [TB_W-1:0] LAST = TB_W'(SAMPLE_CYC - 1);

    logic [TB_W-1:0] tb_cnt;

    assign tick = en && (tb_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_cnt <= '0;
        end else if (en) begin
            tb_cnt <= (tb_cnt == LAST) ? '0 : tb_cnt + 1'b1;
        end
    end

    // R8: time base frozen while disabled
    a_r8_tb_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(tb_cnt));

    // R3: counter stays inside one interval
    always_comb begin
        if (!rst) a_r3_tb_range: assert (tb_cnt <= LAST);
    end

endmodule

// File: rtl/evwin_ctr.sv
module evwin_ctr #(
    parameter int CNT_W = 8
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    en,
    input  logic                                    snap,
    input  logic [evwin_pkg::NUM_EV-1:0]            ev_strobe,
    output logic [evwin_pkg::NUM_EV-1:0][CNT_W-1:0] snap_val
);
    import evwin_pkg::*;

    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [NUM_EV-1:0][CNT_W-1:0] cnt;

    assign snap_val = cnt;

    for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
        logic hit;
        assign hit = en && ev_strobe[e];

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[e] <= '0;
            end else if (snap) begin
                cnt[e] <= hit ? CNT_W'(1) : '0;
            end else if (hit && (cnt[e] != CMAX)) begin
                cnt[e] <= cnt[e] + 1'b1;
            end
        end

        // R3: a capture restarts the count at the strobe of that cycle
        a_r3_restart: assert property (@(posedge clk) disable iff (rst)
            snap |=> (cnt[e] <= CNT_W'(1)));

        // R2: a full counter does not wrap between captures
        a_r2_saturate: assert property (@(posedge clk) disable iff (rst)
            (!snap && cnt[e] == CMAX) |=> (cnt[e] == CMAX));

        // R8: no counting while disabled
        a_r8_ctr_hold: assert property (@(posedge clk) disable iff (rst)
            (!en && !snap) |=> $stable(cnt[e]));
    end

endmodule

// File: rtl/evwin_buf.sv
module evwin_buf #(
    parameter int CNT_W   = 8,
    parameter int WIN_LEN = 100
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    push,
    input  logic [evwin_pkg::NUM_EV-1:0][CNT_W-1:0] sample,
    input  logic                                    win_ack,
    input  logic [evwin_pkg::idx_width(WIN_LEN)-1:0] rd_idx,
    output logic                                    win_valid,
    output logic                                    overrun,
    output logic [evwin_pkg::NUM_EV*CNT_W-1:0]      rd_data
);
    import evwin_pkg::*;

    localparam int HALF   = win_half(WIN_LEN);
    localparam int FILL_W = $clog2(WIN_LEN + 1);

    typedef logic [NUM_EV-1:0][CNT_W-1:0] sample_t;

    sample_t sbuf  [WIN_LEN];
    sample_t snext [WIN_LEN];
    sample_t wbuf  [WIN_LEN];

    logic [FILL_W-1:0] fill;
    logic              emit;

    for (genvar k = 0; k < WIN_LEN; k++) begin : g_shift
        if (k == WIN_LEN - 1) begin : g_top
            assign snext[k] = sample;
        end else begin : g_mid
            assign snext[k] = sbuf[k+1];
        end
    end

    assign emit = push && (fill == FILL_W'(WIN_LEN - 1));

    always_ff @(posedge clk) begin
        if (push) begin
            for (int k = 0; k < WIN_LEN; k++) sbuf[k] <= snext[k];
        end
        if (emit) begin
            for (int k = 0; k < WIN_LEN; k++) wbuf[k] <= snext[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill      <= '0;
            win_valid <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (emit) begin
                fill <= FILL_W'(HALF);
            end else if (push) begin
                fill <= fill + 1'b1;
            end
            if (emit) begin
                win_valid <= 1'b1;
                if (win_valid && !win_ack) overrun <= 1'b1;
            end else if (win_ack) begin
                win_valid <= 1'b0;
            end
        end
    end

    always_comb begin
        if (int'(rd_idx) < WIN_LEN) rd_data = wbuf[rd_idx];
        else                        rd_data = '0;
    end

    // R6: an unacknowledged window stays valid
    a_r6_valid_hold: assert property (@(posedge clk) disable iff (rst)
        (win_valid && !win_ack) |=> win_valid);

    // R7: overrun is sticky
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R7: replacing a pending window raises overrun
    a_r7_overrun_set: assert property (@(posedge clk) disable iff (rst)
        (win_valid && !win_ack && emit) |=> overrun);

    // R5: fill level never reaches a full window
    always_comb begin
        if (!rst) a_r5_fill_range: assert (int'(fill) < WIN_LEN);
    end

endmodule

// File: rtl/evwin_top.sv
module evwin_top #(
    parameter int SAMPLE_CYC = 100,
    parameter int CNT_W      = 8,
    parameter int WIN_LEN    = 100
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     en,
    input  logic [evwin_pkg::NUM_EV-1:0]             ev_strobe,
    input  logic                                     win_ack,
    input  logic [evwin_pkg::idx_width(WIN_LEN)-1:0] rd_idx,
    output logic                                     win_valid,
    output logic                                     overrun,
    output logic [evwin_pkg::NUM_EV*CNT_W-1:0]       rd_data
);
    import evwin_pkg::*;

    logic                         tick;
    logic [NUM_EV-1:0][CNT_W-1:0] snap_val;

    evwin_tick #(.SAMPLE_CYC(SAMPLE_CYC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .tick (tick)
    );

    evwin_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .snap      (tick),
        .ev_strobe (ev_strobe),
        .snap_val  (snap_val)
    );

    evwin_buf #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (tick),
        .sample    (snap_val),
        .win_ack   (win_ack),
        .rd_idx    (rd_idx),
        .win_valid (win_valid),
        .overrun   (overrun),
        .rd_data   (rd_data)
    );

    // R9: flags come out of reset low
    a_r9_reset_flags: assert property (@(posedge clk)
        rst |=> (!win_valid && !overrun));

endmodule

// File: tb/tb_evwin_top.sv
module tb_evwin_top;

    localparam int S    = 8;
    localparam int CW   = 3;
    localparam int W    = 6;
    localparam int H    = W / 2;
    localparam int MAXV = (1 << CW) - 1;
    localparam int NE   = 7;
    localparam int RW   = $clog2(W);

    logic          clk = 0;
    logic          rst = 1;
    logic          en = 0;
    logic [NE-1:0] ev_strobe = '0;
    logic          win_ack = 0;
    logic [RW-1:0] rd_idx = '0;
    logic          win_valid;
    logic          overrun;
    logic [NE*CW-1:0] rd_data;

    evwin_top #(.SAMPLE_CYC(S), .CNT_W(CW), .WIN_LEN(W)) dut (
        .clk(clk), .rst(rst), .en(en), .ev_strobe(ev_strobe),
        .win_ack(win_ack), .rd_idx(rd_idx), .win_valid(win_valid),
        .overrun(overrun), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int samp [0:1023][NE];
    int acc [NE];
    int nsamp, tbc, last_start;
    bit mv, mov, ack_next, auto_ack;
    string ctx;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NE; i++) acc[i] = 0;
        nsamp = 0; tbc = 0; mv = 0; mov = 0; ack_next = 0;
    endtask

    task automatic read_check(input int start);
        for (int k = 0; k < W; k++) begin
            rd_idx = RW'(k);
            #1;
            for (int i = 0; i < NE; i++) begin
                int got, exp;
                got = int'(rd_data[i*CW +: CW]);
                exp = samp[start+k][i];
                chk(got == exp, {ctx, " R10 window sample"}, got, exp);
            end
        end
        rd_idx = RW'(W);
        #1;
        chk(rd_data == '0, "R10 out of range index", int'(rd_data), 0);
    endtask

    task automatic step(input logic [NE-1:0] s, input logic e);
        bit emitted, tick, ack_now;
        ev_strobe = s; en = e; win_ack = ack_next;
        ack_now = ack_next; ack_next = 0;
        @(posedge clk);
        emitted = 0;
        if (e) begin
            tick = (tbc == S - 1);
            if (tick) begin
                for (int i = 0; i < NE; i++) begin
                    samp[nsamp][i] = acc[i];
                    acc[i] = int'(s[i]);
                end
                nsamp++;
                tbc = 0;
                if (nsamp == W || (nsamp > W && (nsamp - W) % H == 0)) begin
                    emitted = 1;
                    last_start = nsamp - W;
                end
            end else begin
                for (int i = 0; i < NE; i++)
                    acc[i] = (acc[i] + int'(s[i]) > MAXV) ? MAXV : acc[i] + int'(s[i]);
                tbc++;
            end
        end
        if (emitted) begin
            if (mv && !ack_now) mov = 1;
            mv = 1;
        end else if (ack_now) begin
            mv = 0;
        end
        @(negedge clk);
        chk(win_valid == mv, "R4 R5 R6 win_valid", int'(win_valid), int'(mv));
        chk(overrun == mov, "R7 overrun", int'(overrun), int'(mov));
        if (emitted && auto_ack) begin
            read_check(last_start);
            ack_next = 1;
        end
    endtask

    task automatic do_reset();
        rst = 1; en = 0; ev_strobe = '0; win_ack = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_clear();
        chk(win_valid == 0, "R9 win_valid after reset", int'(win_valid), 0);
        chk(overrun == 0, "R9 overrun after reset", int'(overrun), 0);
    endtask

    function automatic logic [NE-1:0] pat1(input int c);
        logic [NE-1:0] v;
        for (int i = 0; i < NE; i++) v[i] = ((c + 3 * i) % (i + 2)) == 0;
        return v;
    endfunction

    function automatic logic [NE-1:0] pat2(input int c);
        logic [NE-1:0] v;
        for (int i = 0; i < NE; i++) v[i] = ((c * 7 + i * 5) % 11) < (i % 4 + 2);
        return v;
    endfunction

    initial begin
        auto_ack = 1;
        @(negedge clk);
        do_reset();

        ctx = "R1 R3 R4 R5";
        for (int c = 0; c < 150; c++) step(pat1(c), 1'b1);

        ctx = "R2 saturation";
        for (int c = 0; c < 80; c++) step('1, 1'b1);

        ctx = "R8 enable gaps";
        for (int c = 0; c < 120; c++) step(pat2(c), (c % 3) != 0);

        ctx = "R7 overwrite";
        auto_ack = 0;
        for (int c = 0; c < 60; c++) step(pat1(c + 7), 1'b1);
        read_check(last_start);
        ack_next = 1;
        auto_ack = 1;
        step(pat1(3), 1'b1);
        step(pat1(4), 1'b1);

        ctx = "R9 R4 after reset";
        do_reset();
        for (int c = 0; c < 100; c++) step(pat2(c + 2), 1'b1);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule